// File: doc/BRIEF.md
# Protection Identifier Matcher

This block decides which access permissions a page's protection identifier is granted. It holds four 64-bit protection-identifier registers, which software loads through a small write port. For each lookup, the block searches those registers for a candidate whose identifier field equals the low 16 bits of the access identifier. It returns a three-bit permission mask with separate bits for execute, read and write.

Each candidate is a 32-bit word. Bits 16:1 of the word hold the identifier. Bit 0 is a write-disable flag. In narrow mode only the low word of each register is a candidate. In wide mode both words of each register are candidates. The first matching candidate in search order decides the grant. A mask of zero means that no candidate matched. The consumer turns the result into faults.

A parameter inserts an output register. With the register, the result appears one cycle after the request, together with a valid flag.

Top module: `pid_match_unit`

## Requirements
- R1: A synchronous active-low reset clears all four registers to zero and drives `out_valid` and `out_perm` to zero. After reset, a lookup of identifier 0 therefore grants 3'b111, and a lookup of any other identifier grants 3'b000.
- R2: When `wr_en` is high at a clock edge, register `wr_idx` takes all 64 bits of `wr_data`, and the other registers keep their values. A lookup requested in the same cycle as a write sees the register contents from before the write.
- R3: A candidate word matches when its bits 16:1 equal `access_id[15:0]`. Bits 31:17 of the candidate and `access_id[31:16]` have no effect on the result.
- R4: `out_perm` encodes execute in bit 2, read in bit 1 and write in bit 0. A match on a candidate with bit 0 set grants 3'b110. A match on a candidate with bit 0 clear grants 3'b111. No other non-zero value ever appears.
- R5: When no candidate matches, `out_perm` is 3'b000.
- R6: In narrow mode (`wide_mode`=0), the registers are searched from index 0 up to index 3, and the first match determines the grant.
- R7: In narrow mode, bits 63:32 of every register have no effect on the result.
- R8: In wide mode (`wide_mode`=1), the search order is: register 0 low word, register 0 high word, register 1 low word, register 1 high word, and so on. The first match determines the grant.
- R9: With the output register enabled (the default), `out_valid` equals `req_valid` delayed by one clock, and `out_perm` carries the result of that request. When `out_valid` is 0, `out_perm` is 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 2 | Index of the register to write |
| wr_data | input | 64 | Value to write |
| req_valid | input | 1 | Lookup request |
| wide_mode | input | 1 | 1: both words of each register are candidates; 0: low words only |
| access_id | input | 32 | Access identifier; only bits 15:0 are compared |
| out_valid | output | 1 | Result valid |
| out_perm | output | 3 | Granted permissions {execute, read, write} |

## Verification
Every cycle, the assertions check four things. The mask only ever takes one of the three legal values. A cycle with no hit yields a zero mask. Narrow mode never selects a high word. Reset, writes and the valid pipeline keep their timing. Only the bench scenarios can show that the correct candidate wins. Those scenarios cover first-match order across registers, low-before-high order within a register in wide mode, and the identifier bits that must be ignored. They also cover the case where a lookup and a write to the same register fall in the same cycle.

// File: rtl/pid_match_pkg.sv
// Package: shared permission type and grant encoding for the matcher.
// Assumes a three-bit mask ordered {execute, read, write}.
package pid_match_pkg;
    typedef logic [2:0] perm_t;

    localparam perm_t PERM_NONE = 3'b000;
    localparam perm_t PERM_RX   = 3'b110;
    localparam perm_t PERM_RWX  = 3'b111;

    // Grant for a matching candidate, given its write-disable bit.
    function automatic perm_t grant_of(input logic wr_disable);
        return wr_disable ? PERM_RX : PERM_RWX;
    endfunction
endpackage

// File: rtl/pid_reg_file.sv
// Module: storage for the protection-identifier registers.
// One register is written per cycle. Synchronous active-low reset clears all registers.
// The contents are exported flat, with register 0 in the lowest bits.
module pid_reg_file #(
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 64,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [REG_W-1:0]          wr_data,
    output logic [NUM_REGS*REG_W-1:0] regs_flat
);
    logic [REG_W-1:0] pid_q [NUM_REGS];

    // Reset clear and single-register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) pid_q[i] <= '0;
        end else if (wr_en) begin
            pid_q[wr_idx] <= wr_data;
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign regs_flat[g*REG_W +: REG_W] = pid_q[g];
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (regs_flat == '0)); // R1

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (pid_q[$past(wr_idx)] == $past(wr_data))); // R2
endmodule

// File: rtl/pid_candidate_cmp.sv
// Module: compares one 32-bit candidate word against the access identifier.
// Bits CMP_W:1 of the candidate hold the identifier. Bit 0 is the write-disable flag.
// Assumes ACC_W > CMP_W and HALF_W > CMP_W + 1.
module pid_candidate_cmp
    import pid_match_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter int CMP_W  = 16,
    parameter int ACC_W  = 32
) (
    input  logic [HALF_W-1:0] cand,
    input  logic [ACC_W-1:0]  access_id,
    input  logic              enable,
    output logic              hit,
    output perm_t             grant
);
    logic unused_bits;

    // Identifier field compare, gated by the candidate enable.
    always_comb begin
        hit   = enable && (cand[CMP_W:1] == access_id[CMP_W-1:0]);
        grant = grant_of(cand[0]);
    end

    assign unused_bits = ^{cand[HALF_W-1:CMP_W+1], access_id[ACC_W-1:CMP_W]};
endmodule

// File: rtl/pid_priority_sel.sv
// Module: first-match selector. The lowest-numbered hit wins.
// Candidate index order is the search order.
module pid_priority_sel
    import pid_match_pkg::*;
#(
    parameter int NUM_CAND = 8,
    localparam int SEL_W   = (NUM_CAND > 1) ? $clog2(NUM_CAND) : 1
) (
    input  logic [NUM_CAND-1:0]   hit_vec,
    input  logic [3*NUM_CAND-1:0] grant_flat,
    output perm_t                 mask,
    output logic                  any_hit,
    output logic [SEL_W-1:0]      sel_idx
);
    // Scan in search order and keep the first hit.
    always_comb begin
        mask    = PERM_NONE;
        any_hit = 1'b0;
        sel_idx = '0;
        for (int i = 0; i < NUM_CAND; i++) begin
            if (hit_vec[i] && !any_hit) begin
                any_hit = 1'b1;
                mask    = grant_flat[3*i +: 3];
                sel_idx = SEL_W'(i);
            end
        end
    end
endmodule

// File: rtl/pid_match_unit.sv
// Module: top of the protection-identifier matcher.
// Builds two candidates per register, with the low word first. High words are enabled only in wide mode.
// Selects the first hit and optionally registers the result.
// Assumes REG_W == 2*HALF_W.
module pid_match_unit
    import pid_match_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 64,
    parameter int CMP_W    = 16,
    parameter int ACC_W    = 32,
    parameter bit OUT_REG  = 1'b1,
    localparam int HALF_W   = REG_W / 2,
    localparam int NUM_CAND = 2 * NUM_REGS,
    localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int SEL_W    = (NUM_CAND > 1) ? $clog2(NUM_CAND) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [REG_W-1:0] wr_data,
    input  logic             req_valid,
    input  logic             wide_mode,
    input  logic [ACC_W-1:0] access_id,
    output logic             out_valid,
    output logic [2:0]       out_perm
);
    logic [NUM_REGS*REG_W-1:0] regs_flat;
    logic [NUM_CAND-1:0]       hit_vec;
    logic [3*NUM_CAND-1:0]     grant_flat;
    perm_t                     sel_mask;
    logic                      any_hit;
    logic [SEL_W-1:0]          sel_idx;

    pid_reg_file #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .regs_flat(regs_flat)
    );

    // Candidate k = 2*reg + half, which is also the search order.
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        for (genvar h = 0; h < 2; h++) begin : g_half
            localparam int K = 2*r + h;
            perm_t g_grant;
            pid_candidate_cmp #(.HALF_W(HALF_W), .CMP_W(CMP_W), .ACC_W(ACC_W)) u_cmp (
                .cand(regs_flat[r*REG_W + h*HALF_W +: HALF_W]),
                .access_id(access_id),
                .enable((h == 0) ? 1'b1 : wide_mode),
                .hit(hit_vec[K]),
                .grant(g_grant)
            );
            assign grant_flat[3*K +: 3] = g_grant;
        end
    end

    pid_priority_sel #(.NUM_CAND(NUM_CAND)) u_sel (
        .hit_vec(hit_vec), .grant_flat(grant_flat),
        .mask(sel_mask), .any_hit(any_hit), .sel_idx(sel_idx)
    );

    if (OUT_REG) begin : g_oreg
        // One-cycle result stage; the mask is zero when there is no request.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                out_perm  <= PERM_NONE;
            end else begin
                out_valid <= req_valid;
                out_perm  <= req_valid ? sel_mask : PERM_NONE;
            end
        end

        AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (out_valid == $past(req_valid))); // R9
    end else begin : g_comb
        // Pass-through variant with no added latency.
        always_comb begin
            out_valid = req_valid;
            out_perm  = req_valid ? sel_mask : PERM_NONE;
        end
    end

    AST_NO_HIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |-> (sel_mask == PERM_NONE)); // R5

    AST_NARROW_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_mode && any_hit) |-> (sel_idx[0] == 1'b0)); // R7

    AST_LEGAL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_perm == PERM_NONE) || (out_perm == PERM_RX) || (out_perm == PERM_RWX)); // R4

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_perm == PERM_NONE)); // R9
endmodule

// File: tb/pid_match_unit_test.sv
module pid_match_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic        wide_mode = 1'b0;
    logic [31:0] access_id = '0;
    logic        out_valid;
    logic [2:0]  out_perm;

    int n_checks = 0;
    int n_fail = 0;
    logic [63:0] mdl [4];
    logic [15:0] pool [8];

    always #10 clk = ~clk;

    pid_match_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .req_valid(req_valid), .wide_mode(wide_mode), .access_id(access_id),
        .out_valid(out_valid), .out_perm(out_perm)
    );

    function automatic logic [2:0] expect_perm(input logic wide, input logic [31:0] id);
        for (int r = 0; r < 4; r++) begin
            for (int h = 0; h < 2; h++) begin
                logic [31:0] c;
                c = mdl[r][h*32 +: 32];
                if ((h == 0 || wide) && c[16:1] == id[15:0])
                    return c[0] ? 3'b110 : 3'b111;
            end
        end
        return 3'b000;
    endfunction

    function automatic logic [31:0] mk_cand(input logic [14:0] top, input logic [15:0] id,
                                            input logic wd);
        return {top, id, wd};
    endfunction

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] idx, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        mdl[idx] = d;
    endtask

    // Lookup, optionally with a write in the same cycle. The expected value uses the contents before the write.
    task automatic do_lookup(input string tag, input logic wide, input logic [31:0] id,
                             input logic with_wr, input logic [1:0] idx, input logic [63:0] d);
        logic [2:0] exp;
        @(negedge clk);
        exp = expect_perm(wide, id);
        req_valid = 1'b1; wide_mode = wide; access_id = id;
        wr_en = with_wr; wr_idx = idx; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        if (with_wr) mdl[idx] = d;
        check({tag, " valid"}, {3'b0, out_valid}, 4'd1);
        check(tag, {1'b0, out_perm}, {1'b0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state of outputs
        check("R1 reset valid", {3'b0, out_valid}, 4'd0);
        check("R1 reset perm", {1'b0, out_perm}, 4'd0);
        rst_n = 1'b1;
        // R1: cleared registers match identifier 0 with full grant
        do_lookup("R1 id0", 1'b0, 32'h0, 1'b0, 2'd0, 64'd0);
        check("R1 id0 value", {1'b0, out_perm}, 4'b0111);
        do_lookup("R5 no match", 1'b0, 32'h1, 1'b0, 2'd0, 64'd0);
        check("R5 zero", {1'b0, out_perm}, 4'b0000);

        // R2/R4: write register 2 with write-disable set
        do_write(2'd2, {32'h0, mk_cand(15'h0, 16'h00A5, 1'b1)});
        do_lookup("R4 rx", 1'b0, 32'h0000_00A5, 1'b0, 2'd0, 64'd0);
        check("R4 rx value", {1'b0, out_perm}, 4'b0110);
        // R3: upper access_id bits ignored
        do_lookup("R3 id upper", 1'b0, 32'hFFFF_00A5, 1'b0, 2'd0, 64'd0);
        check("R3 id upper value", {1'b0, out_perm}, 4'b0110);
        // R6: register 1 precedes register 2
        do_write(2'd1, {32'h0, mk_cand(15'h0, 16'h00A5, 1'b0)});
        do_lookup("R6 order", 1'b0, 32'h00A5, 1'b0, 2'd0, 64'd0);
        check("R6 order value", {1'b0, out_perm}, 4'b0111);
        // R7/R8: high word of register 0
        do_write(2'd0, {mk_cand(15'h0, 16'h00A5, 1'b1), mk_cand(15'h0, 16'h1111, 1'b0)});
        do_lookup("R7 narrow ignores high", 1'b0, 32'h00A5, 1'b0, 2'd0, 64'd0);
        check("R7 value", {1'b0, out_perm}, 4'b0111);
        do_lookup("R8 wide reg0 high first", 1'b1, 32'h00A5, 1'b0, 2'd0, 64'd0);
        check("R8 value", {1'b0, out_perm}, 4'b0110);
        // R8: low word before high word within a register
        do_write(2'd3, {mk_cand(15'h0, 16'h3C3C, 1'b0), mk_cand(15'h0, 16'h3C3C, 1'b1)});
        do_lookup("R8 low first", 1'b1, 32'h3C3C, 1'b0, 2'd0, 64'd0);
        check("R8 low value", {1'b0, out_perm}, 4'b0110);
        // R3: candidate bits 31:17 ignored
        do_write(2'd3, {32'h0, mk_cand(15'h7FFF, 16'h7777, 1'b0)});
        do_lookup("R3 cand upper", 1'b0, 32'h7777, 1'b0, 2'd0, 64'd0);
        check("R3 cand value", {1'b0, out_perm}, 4'b0111);
        // R2: same-cycle write sees old contents, then new
        do_lookup("R2 old", 1'b0, 32'h7777, 1'b1, 2'd3, {32'h0, mk_cand(15'h0, 16'h7777, 1'b1)});
        check("R2 old value", {1'b0, out_perm}, 4'b0111);
        do_lookup("R2 new", 1'b0, 32'h7777, 1'b0, 2'd0, 64'd0);
        check("R2 new value", {1'b0, out_perm}, 4'b0110);
        // R9: idle cycle gives zero valid and mask
        @(negedge clk);
        access_id = 32'h7777;
        @(negedge clk);
        check("R9 idle valid", {3'b0, out_valid}, 4'd0);
        check("R9 idle perm", {1'b0, out_perm}, 4'd0);

        // Random mix: writes built from an identifier pool, then lookups (R6 R8 R5)
        for (int i = 0; i < 8; i++) pool[i] = 16'($urandom);
        for (int it = 0; it < 3000; it++) begin
            int sel;
            sel = int'($urandom % 4);
            if (sel == 0) begin
                logic [63:0] d;
                d = {mk_cand(15'($urandom), pool[$urandom % 8], 1'($urandom)),
                     mk_cand(15'($urandom), pool[$urandom % 8], 1'($urandom))};
                do_write(2'($urandom), d);
            end else begin
                logic [31:0] id;
                id = ($urandom % 5 == 0) ? $urandom : {16'($urandom), pool[$urandom % 8]};
                do_lookup("R6/R8 random", 1'($urandom), id, 1'($urandom % 6 == 0),
                          2'($urandom), {$urandom, $urandom});
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule